// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block collects the interrupt causes of a serial port and turns them into one interrupt line. Five live status levels (receive threshold reached, receive queue empty, receive queue full, transmit queue empty, transmit queue full) and five single-cycle event pulses (receive overrun, framing error, parity error, receive timeout, modem line change) are latched into a sticky status register. Software clears bits of that register by writing ones to it. A bit whose level input is still high at a clock edge is set again at that edge, so a condition that lasts cannot be lost by clearing it.

The mask register has no direct write path. Software widens it through a set port that ORs the written word in, and narrows it through a clear port that removes the bits written as ones. The register at the mask address can only be read. The interrupt output is a register. It goes high one cycle after any bit is both enabled in the mask and present in the sticky status.

The register port is plain control signalling: address, write data and write strobe, with read data decoded combinationally from the address. No transfer here is a data stream, so the port has no valid/ready handshake and never applies back-pressure. A write is accepted in every cycle in which the strobe is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask register, the sticky status register and `irq` are all zero.
- R2: Status bit i (bits 0 to 4) is set at every clock edge where `lvl_in[i]` is high. It stays set after the level falls, until software clears it.
- R3: A one-cycle pulse on `evt_in[j]` sets status bit 5+j at that edge (bit 5 overrun, 6 framing, 7 parity, 8 timeout, 9 modem change). The bit stays set until software clears it.
- R4: A write to address 3 (status) clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R5: When a status clear and a set cause (level or pulse) hit the same bit at the same edge, the bit ends up set.
- R6: A write to address 0 (mask set) ORs the write data into the mask.
- R7: A write to address 1 (mask clear) clears each mask bit written as 1.
- R8: Writes to address 2 (mask, read-only) and to addresses 4 to 7 change neither the mask nor the status.
- R9: `irq` is a register. In each cycle it equals the OR of (mask AND status) as those registers stood one cycle earlier.
- R10: With `we` low, `rd_data` shows the mask when `addr` is 2 and the status when `addr` is 3. It reads zero for every other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (3) | Register address |
| wr_data | input | N_LVL+N_EVT (10) | Write data |
| we | input | 1 | Write strobe, one write per high cycle |
| rd_data | output | N_LVL+N_EVT (10) | Read data for `addr` |
| lvl_in | input | N_LVL (5) | Live status levels |
| evt_in | input | N_EVT (5) | Single-cycle event pulses |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach from the ports is a status clear landing at the same edge as a fresh set cause for the same bit. Random traffic rarely lines these up, and the outcome is visible only if the status is read back afterwards. Directed steps hold a level, and separately fire a pulse, in the same cycle as a clear write covering that bit. Random cycles then mix clear writes with sparse levels and pulses, so that collisions also happen on other bits. After every cycle the mask, the status and `irq` are compared with a bench model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Register address map (behavioural: software relies on these values)
  localparam int unsigned A_MASK_SET = 0;
  localparam int unsigned A_MASK_CLR = 1;
  localparam int unsigned A_MASK_RD  = 2;
  localparam int unsigned A_STATUS   = 3;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT
  } rd_sel_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (set_en) mask_d = mask_d | bits;
    if (clr_en) mask_d = mask_d & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // A set cause at the same edge as a clear keeps the bit set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat[i] <= 1'b0;
      else if (set_vec[i]) stat[i] <= 1'b1;
      else if (clr_vec[i]) stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] stat,
  output logic         irq
);
  logic pending;

  assign pending = |(mask & stat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LVL  = 5,
  parameter int unsigned N_EVT  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [N_LVL+N_EVT-1:0] wr_data,
  input  logic                   we,
  output logic [N_LVL+N_EVT-1:0] rd_data,
  input  logic [N_LVL-1:0]       lvl_in,
  input  logic [N_EVT-1:0]       evt_in,
  output logic                   irq
);
  localparam int unsigned NSRC = N_LVL + N_EVT;

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic            wr_mset;
  logic            wr_mclr;
  logic            wr_stat;
  rd_sel_e         rd_sel;

  // Write decode; the read-only mask address and unmapped ones fall through
  assign wr_mset = we && (addr == ADDR_W'(A_MASK_SET));
  assign wr_mclr = we && (addr == ADDR_W'(A_MASK_CLR));
  assign wr_stat = we && (addr == ADDR_W'(A_STATUS));

  // Levels occupy the low bits, event pulses sit directly above them
  assign set_vec = {evt_in, lvl_in};
  assign clr_vec = wr_stat ? wr_data : '0;

  irq_mask_reg #(.W(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_mset),
    .clr_en (wr_mclr),
    .bits   (wr_data),
    .mask   (mask_q)
  );

  irq_sticky_bank #(.W(NSRC)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat    (stat_q)
  );

  irq_out_reg #(.W(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (mask_q),
    .stat  (stat_q),
    .irq   (irq)
  );

  always_comb begin
    if (addr == ADDR_W'(A_MASK_RD))     rd_sel = SEL_MASK;
    else if (addr == ADDR_W'(A_STATUS)) rd_sel = SEL_STAT;
    else                                rd_sel = SEL_NONE;
  end

  always_comb begin
    case (rd_sel)
      SEL_MASK: rd_data = mask_q;
      SEL_STAT: rd_data = stat_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LVL  = 5,
  parameter int unsigned N_EVT  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [N_LVL+N_EVT-1:0] wdata,
  input logic                   we,
  input logic [N_LVL-1:0]       lvl,
  input logic [N_EVT-1:0]       evt,
  input logic [N_LVL+N_EVT-1:0] mask,
  input logic [N_LVL+N_EVT-1:0] stat,
  input logic                   irq
);
  localparam int unsigned NSRC = N_LVL + N_EVT;
  logic [NSRC-1:0] cause;
  assign cause = {evt, lvl};

  // R2 R3 R5
  cause_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(cause)) == $past(cause)));

  // R4
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(A_STATUS)) |=> ((stat & $past(wdata & ~cause)) == '0));

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(A_MASK_SET)) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(A_MASK_CLR)) |=> ((mask & $past(wdata)) == '0));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (addr == ADDR_W'(A_MASK_SET) || addr == ADDR_W'(A_MASK_CLR))) |=> $stable(mask));

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask & stat) == '0) |=> !irq);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(mask & stat) != '0));
endmodule

bind uart_irq_ctrl irq_ctrl_chk #(.N_LVL(N_LVL), .N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .wdata (wr_data),
  .we    (we),
  .lvl   (lvl_in),
  .evt   (evt_in),
  .mask  (mask_q),
  .stat  (stat_q),
  .irq   (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  localparam int NL = 5;
  localparam int NE = 5;
  localparam int NS = NL + NE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic [NS-1:0] wr_data = '0;
  logic          we = 1'b0;
  logic [NS-1:0] rd_data;
  logic [NL-1:0] lvl_in = '0;
  logic [NE-1:0] evt_in = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NS-1:0] m_mask = '0;
  logic [NS-1:0] m_stat = '0;
  logic          m_irq  = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .we(we),
    .rd_data(rd_data), .lvl_in(lvl_in), .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model of one edge, from the requirements
  function automatic logic [NS-1:0] nxt_stat(logic [NS-1:0] s, logic w, logic [2:0] a,
                                             logic [NS-1:0] d, logic [NS-1:0] c);
    logic [NS-1:0] clr = (w && a == 3'd3) ? d : '0;
    return (s & ~clr) | c;
  endfunction

  function automatic logic [NS-1:0] nxt_mask(logic [NS-1:0] m, logic w, logic [2:0] a,
                                             logic [NS-1:0] d);
    if (w && a == 3'd0) return m | d;
    if (w && a == 3'd1) return m & ~d;
    return m;
  endfunction

  task automatic read_all(input string req);
    we = 1'b0;
    addr = 3'd2; #0.2; chk({req, " R10 mask"}, rd_data, m_mask);
    addr = 3'd3; #0.2; chk({req, " R10 stat"}, rd_data, m_stat);
    addr = 3'd0; #0.2; chk("R10 set-addr reads 0", rd_data, '0);
    addr = 3'd5; #0.2; chk("R10 unmapped reads 0", rd_data, '0);
  endtask

  // Drive one cycle after a negedge, step model at posedge, check at next negedge
  task automatic step(input string req, input logic w, input logic [2:0] a,
                      input logic [NS-1:0] d, input logic [NL-1:0] l, input logic [NE-1:0] e);
    we = w; addr = a; wr_data = d; lvl_in = l; evt_in = e;
    @(posedge clk);
    m_irq  = |(m_mask & m_stat);
    m_stat = nxt_stat(m_stat, w, a, d, {e, l});
    m_mask = nxt_mask(m_mask, w, a, d);
    @(negedge clk);
    we = 1'b0; evt_in = '0;
    chk({req, " R9 irq"}, NS'(irq), NS'(m_irq));
    read_all(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", NS'(irq), '0);
    addr = 3'd2; #0.2; chk("R1 mask", rd_data, '0);
    addr = 3'd3; #0.2; chk("R1 stat", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 level sets and sticks after it falls
    step("R2 lvl high", 1'b0, 3'd4, '0, 5'b00100, '0);
    step("R2 lvl gone", 1'b0, 3'd4, '0, 5'b00000, '0);
    chk("R2 sticky bit2", m_stat, 10'h004);
    // R3 pulse on overrun and modem change
    step("R3 pulse", 1'b0, 3'd4, '0, '0, 5'b10001);
    step("R3 hold", 1'b0, 3'd4, '0, '0, '0);
    chk("R3 bits 5 and 9", m_stat, 10'h224);
    // R8 direct mask write ignored
    step("R8 mask addr", 1'b1, 3'd2, 10'h3ff, '0, '0);
    step("R8 unmapped", 1'b1, 3'd6, 10'h3ff, '0, '0);
    chk("R8 mask unchanged", m_mask, '0);
    // R6 enable then R9 latency
    step("R6 set", 1'b1, 3'd0, 10'h020, '0, '0);
    chk("R9 irq not yet", NS'(irq), '0);
    step("R9 irq rises", 1'b0, 3'd4, '0, '0, '0);
    chk("R9 irq high", NS'(irq), 10'h001);
    // R5 clear collides with level and with pulse
    step("R5 lvl vs clr", 1'b1, 3'd3, 10'h004, 5'b00100, '0);
    chk("R5 bit2 kept", m_stat & 10'h004, 10'h004);
    step("R5 evt vs clr", 1'b1, 3'd3, 10'h020, '0, 5'b00001);
    chk("R5 bit5 kept", m_stat & 10'h020, 10'h020);
    // R4 clear everything
    step("R4 clear all", 1'b1, 3'd3, 10'h3ff, '0, '0);
    chk("R4 stat zero", m_stat, '0);
    // R7 disable
    step("R7 clr", 1'b1, 3'd1, 10'h020, '0, '0);
    chk("R7 mask zero", m_mask, '0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]    a = 3'($urandom_range(0, 7));
      logic          w = ($urandom_range(0, 3) != 0);
      logic [NS-1:0] d = NS'($urandom);
      logic [NL-1:0] l = NL'($urandom) & NL'($urandom) & NL'($urandom);
      logic [NE-1:0] e = NE'($urandom) & NE'($urandom) & NE'($urandom);
      step("rand R2 R3 R4 R5 R6 R7 R8", w, a, d, l, e);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule